// File: doc/BRIEF.md
# Dual-Channel Asynchronous Serial Controller with Indirect Register Access

This block provides two independent asynchronous serial channels behind a very small host window. Each channel occupies just two host ports: a control port and a data port. A single address bit chooses between them, and the address bits above it choose the channel. The data port moves characters. A write to the data port fills the transmit holding register. A read from the data port takes the last received character.

Every other register of a channel is reached indirectly through the control port. While the channel's register pointer is zero, a control write loads the pointer. The next control access then reads or writes the register that the pointer names. After any access other than a pointer load, the pointer falls back to zero. Software normally sets up a channel by streaming pointer/value byte pairs to its control port.

Each channel has its own programmable baud generator. A 16-bit time constant sets the rate, and the rate is further divided by a selectable oversampling multiplier. The generator drives both the receiver and the transmitter. There is an optional mode in which the transmitter waits for clear-to-send. A sticky interrupt line flags received characters and an emptied transmit buffer, and it stays asserted until it is acknowledged.

Top module: `uart_dual`

## Requirements
- R1: `addr[0]` = 0 selects a channel's control port and `addr[0]` = 1 its data port; `addr[1]` selects the channel (0 or 1), and an access to one channel leaves the other channel's registers unchanged.
- R2: A control write while the pointer is 0 loads the pointer from `wdata[3:0]`. The next control read or write then reaches that register. After any access other than such a pointer load, the pointer returns to 0.
- R3: A control read with pointer 0 returns the status byte: bit 0 = received character available, bit 2 = transmit holding register empty, bit 5 = synchronized CTS level, and all other bits 0. A control read with pointer 1 to 15 returns the value last written to that register.
- R4: After reset the register file and pointer are 0, both `txd` lines are high, `rts`, `dtr` and `irq` are low, and the status byte reads 04h when CTS is low.
- R5: Register 4 sets the character format. Bits 7:6 select the oversampling multiplier: 01 = x16, 10 = x32, 11 = x64, and 00 acts as x16. Bits 3:2 = 11 give two stop bits; any other value gives one. Bit 0 enables a parity bit, and bit 1 selects even parity (1) or odd parity (0).
- R6: Register 5 bit 3 enables the transmitter. Bit 1 drives `rts` and bit 7 drives `dtr`. These pins change only after a host write.
- R7: Register 3 bit 0 enables the receiver. When register 3 bit 5 is set, a character in the holding register is not started while CTS is low, and it starts once CTS is high.
- R8: The time constant TC is {register 13, register 12}. The generator runs only while register 14 bit 0 is 1, and it clocks a direction only when register 11 bits 6:5 (receive) or 4:3 (transmit) equal 10. One bit lasts 2 × M × (TC + 2) clocks, where M is the multiplier. With the generator stopped, a written character stays in the holding register and the line stays high.
- R9: A transmitted frame has one low start bit, then 8 data bits LSB first, then the optional parity bit, then one or two high stop bits.
- R10: The receiver finds a start bit, samples each bit near its middle, and stores the byte after the stop bit, setting the available flag. A data-port read returns the byte and clears the flag.
- R11: Register 1 bit 0 arms an interrupt on a character received, and bit 1 arms one on the holding register being emptied. `irq` stays high after its cause clears, until a clock edge with `int_ack_n` low clears it.
- R12: A data-port write while the holding register is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and baud reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Host access select |
| wr | input | 1 | Host write strobe (one cycle) |
| rd | input | 1 | Host read strobe (one cycle) |
| addr | input | 2 | Bit 0: control/data port, bit 1: channel |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid during the read cycle |
| rxd | input | 2 | Serial receive lines, one per channel |
| cts | input | 2 | Clear-to-send, active high, one per channel |
| txd | output | 2 | Serial transmit lines, idle high |
| rts | output | 2 | Request-to-send pins |
| dtr | output | 2 | Data-terminal-ready pins |
| int_ack_n | input | 1 | Interrupt acknowledge, active low, synchronous |
| irq | output | 1 | Sticky interrupt request |

## Verification
The assertions assume that `int_ack_n` is a synchronous pulse. They also assume that `cs` with `wr` marks the only cycles in which a host write can reach the pin registers. The stimulus changes every input on the falling clock edge, and it never raises `rd` and `wr` together. The stimulus rewrites a channel's format and time constant only while that channel's lines are idle, because the transmitter and receiver use those settings live. Serial input is sent at the exact bit period that the bench computes from the programmed time constant and multiplier, so sampling near mid-bit stays within the tolerance the design relies on.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int DW    = 8;
  localparam int TC_W  = 16;
  localparam int REG_N = 16;
  localparam int PTR_W = $clog2(REG_N);
  localparam int OS_W  = 7;

  localparam logic [PTR_W-1:0] REG_IE   = 4'd1;
  localparam logic [PTR_W-1:0] REG_RXC  = 4'd3;
  localparam logic [PTR_W-1:0] REG_MODE = 4'd4;
  localparam logic [PTR_W-1:0] REG_TXC  = 4'd5;
  localparam logic [PTR_W-1:0] REG_CLK  = 4'd11;
  localparam logic [PTR_W-1:0] REG_TCL  = 4'd12;
  localparam logic [PTR_W-1:0] REG_TCH  = 4'd13;
  localparam logic [PTR_W-1:0] REG_BRG  = 4'd14;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} line_st_t;

  function automatic logic [2:0] os_shift(input logic [1:0] mult);
    case (mult)
      2'b10:   return 3'd5;
      2'b11:   return 3'd6;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/uart_brg.sv
module uart_brg import uart_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [TC_W-1:0] tc,
  output logic            tick
);
  logic [TC_W:0] cnt_q, cnt_d;
  logic          ph_q, ph_d;
  logic [TC_W:0] reload;

  assign reload = {1'b0, tc} + 1'b1;
  assign tick   = en && (cnt_q == '0) && ph_q;

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (!en) begin
      cnt_d = reload;
      ph_d  = 1'b0;
    end else if (cnt_q == '0) begin
      cnt_d = reload;
      ph_d  = ~ph_q;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx import uart_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [2:0]    os_log2,
  input  logic          two_stop,
  input  logic          par_en,
  input  logic          par_even,
  input  logic          start,
  input  logic [DW-1:0] data,
  output logic          take,
  output logic          txd
);
  line_st_t           st_q, st_d;
  logic [DW-1:0]      sh_q, sh_d;
  logic [2:0]         bit_q, bit_d;
  logic [OS_W-1:0]    os_q, os_d;
  logic               par_q, par_d;
  logic [OS_W-1:0]    last;

  assign last = (OS_W'(1) << os_log2) - 1'b1;

  always_comb begin
    st_d = st_q; sh_d = sh_q; bit_d = bit_q; os_d = os_q; par_d = par_q;
    take = 1'b0;
    case (st_q)
      S_START: txd = 1'b0;
      S_DATA:  txd = sh_q[0];
      S_PAR:   txd = par_q;
      default: txd = 1'b1;
    endcase
    if (st_q == S_IDLE) begin
      if (start) begin
        take  = 1'b1;
        sh_d  = data;
        par_d = par_even ? ^data : ~^data;
        os_d  = '0;
        st_d  = S_START;
      end
    end else if (tick) begin
      if (os_q != last) begin
        os_d = os_q + 1'b1;
      end else begin
        os_d = '0;
        case (st_q)
          S_START: begin st_d = S_DATA; bit_d = '0; end
          S_DATA: begin
            sh_d = sh_q >> 1;
            if (bit_q == 3'd7) begin
              st_d  = par_en ? S_PAR : S_STOP;
              bit_d = '0;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end
          S_PAR: begin st_d = S_STOP; bit_d = '0; end
          default: begin
            if (two_stop && bit_q == '0) bit_d = 3'd1;
            else                         st_d  = S_IDLE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; sh_q <= '0; bit_q <= '0; os_q <= '0; par_q <= 1'b0;
    end else begin
      st_q <= st_d; sh_q <= sh_d; bit_q <= bit_d; os_q <= os_d; par_q <= par_d;
    end
  end
endmodule

// File: rtl/uart_rx.sv
module uart_rx import uart_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic [2:0]    os_log2,
  input  logic          par_en,
  input  logic          rxd_s,
  output logic          done,
  output logic [DW-1:0] data
);
  line_st_t        st_q, st_d;
  logic [DW-1:0]   sh_q, sh_d;
  logic [2:0]      bit_q, bit_d;
  logic [OS_W-1:0] os_q, os_d;
  logic [OS_W-1:0] full_m1, half_m1, target;

  assign full_m1 = (OS_W'(1) << os_log2) - 1'b1;
  assign half_m1 = (OS_W'(1) << (os_log2 - 3'd1)) - 1'b1;
  assign target  = (st_q == S_START) ? half_m1 : full_m1;
  assign data    = sh_q;

  always_comb begin
    st_d = st_q; sh_d = sh_q; bit_d = bit_q; os_d = os_q;
    done = 1'b0;
    if (tick) begin
      if (st_q == S_IDLE) begin
        if (!rxd_s) begin st_d = S_START; os_d = '0; end
      end else if (os_q != target) begin
        os_d = os_q + 1'b1;
      end else begin
        os_d = '0;
        case (st_q)
          S_START: begin
            st_d  = rxd_s ? S_IDLE : S_DATA;
            bit_d = '0;
          end
          S_DATA: begin
            sh_d = {rxd_s, sh_q[DW-1:1]};
            if (bit_q == 3'd7) st_d = par_en ? S_PAR : S_STOP;
            else               bit_d = bit_q + 1'b1;
          end
          S_PAR:   st_d = S_STOP;
          default: begin done = 1'b1; st_d = S_IDLE; end
        endcase
      end
    end
    if (!en) st_d = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; sh_q <= '0; bit_q <= '0; os_q <= '0;
    end else begin
      st_q <= st_d; sh_q <= sh_d; bit_q <= bit_d; os_q <= os_d;
    end
  end
endmodule

// File: rtl/uart_chan.sv
module uart_chan import uart_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic          rd,
  input  logic          is_data,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          rxd,
  input  logic          cts,
  input  logic          int_ack_n,
  output logic          txd,
  output logic          rts,
  output logic          dtr,
  output logic          irq
);
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [DW-1:0]    wreg_q [REG_N];
  logic             wreg_we;
  logic             hold_full_q, hold_full_d;
  logic [DW-1:0]    hold_q, hold_d;
  logic             avail_q, avail_d;
  logic [DW-1:0]    rbuf_q, rbuf_d;
  logic             irq_q, irq_d;
  logic             cts_m, cts_s, rxd_m, rxd_s;
  logic             ctrl_wr, ctrl_rd, data_wr, data_rd;
  logic             brg_tick, tx_start, tx_take, rx_done;
  logic [DW-1:0]    rx_data, rr0;
  logic [2:0]       os_log2;
  logic             tx_clk_ok, rx_clk_ok;

  assign ctrl_wr = sel && wr && !is_data;
  assign ctrl_rd = sel && rd && !is_data;
  assign data_wr = sel && wr &&  is_data;
  assign data_rd = sel && rd &&  is_data;
  assign wreg_we = ctrl_wr && (ptr_q != '0);

  assign os_log2   = os_shift(wreg_q[REG_MODE][7:6]);
  assign tx_clk_ok = wreg_q[REG_BRG][0] && (wreg_q[REG_CLK][4:3] == 2'b10);
  assign rx_clk_ok = wreg_q[REG_BRG][0] && (wreg_q[REG_CLK][6:5] == 2'b10);
  assign tx_start  = hold_full_q && wreg_q[REG_TXC][3] && tx_clk_ok &&
                     (!wreg_q[REG_RXC][5] || cts_s);

  assign rr0   = {2'b00, cts_s, 2'b00, !hold_full_q, 1'b0, avail_q};
  assign rdata = is_data ? rbuf_q : ((ptr_q == '0) ? rr0 : wreg_q[ptr_q]);
  assign rts   = wreg_q[REG_TXC][1];
  assign dtr   = wreg_q[REG_TXC][7];
  assign irq   = irq_q;

  uart_brg u_brg (
    .clk(clk), .rst_n(rst_n), .en(wreg_q[REG_BRG][0]),
    .tc({wreg_q[REG_TCH], wreg_q[REG_TCL]}), .tick(brg_tick)
  );

  uart_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(brg_tick && tx_clk_ok), .os_log2(os_log2),
    .two_stop(wreg_q[REG_MODE][3:2] == 2'b11), .par_en(wreg_q[REG_MODE][0]),
    .par_even(wreg_q[REG_MODE][1]), .start(tx_start), .data(hold_q),
    .take(tx_take), .txd(txd)
  );

  uart_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(brg_tick && rx_clk_ok), .en(wreg_q[REG_RXC][0]),
    .os_log2(os_log2), .par_en(wreg_q[REG_MODE][0]), .rxd_s(rxd_s),
    .done(rx_done), .data(rx_data)
  );

  always_comb begin
    ptr_d       = ptr_q;
    hold_full_d = hold_full_q;
    hold_d      = hold_q;
    avail_d     = avail_q;
    rbuf_d      = rbuf_q;
    irq_d       = irq_q;
    if (ctrl_wr && ptr_q == '0)      ptr_d = wdata[PTR_W-1:0];
    else if (sel && (wr || rd))      ptr_d = '0;
    if (tx_take)                     hold_full_d = 1'b0;
    else if (data_wr && !hold_full_q) begin
      hold_full_d = 1'b1;
      hold_d      = wdata;
    end
    if (rx_done) begin
      avail_d = 1'b1;
      rbuf_d  = rx_data;
    end else if (data_rd) begin
      avail_d = 1'b0;
    end
    if (!int_ack_n) irq_d = 1'b0;
    else if ((rx_done && wreg_q[REG_IE][0]) || (tx_take && wreg_q[REG_IE][1]))
      irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0; hold_full_q <= 1'b0; hold_q <= '0; avail_q <= 1'b0;
      rbuf_q <= '0; irq_q <= 1'b0;
      cts_m <= 1'b0; cts_s <= 1'b0; rxd_m <= 1'b1; rxd_s <= 1'b1;
    end else begin
      ptr_q <= ptr_d; hold_full_q <= hold_full_d; hold_q <= hold_d;
      avail_q <= avail_d; rbuf_q <= rbuf_d; irq_q <= irq_d;
      cts_m <= cts; cts_s <= cts_m; rxd_m <= rxd; rxd_s <= rxd_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_N; i++) wreg_q[i] <= '0;
    end else if (wreg_we) begin
      wreg_q[ptr_q] <= wdata;
    end
  end
endmodule

// File: rtl/uart_dual.sv
module uart_dual import uart_pkg::*; #(
  parameter int NCH    = 2,
  parameter int ADDR_W = 1 + $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NCH-1:0]    rxd,
  input  logic [NCH-1:0]    cts,
  output logic [NCH-1:0]    txd,
  output logic [NCH-1:0]    rts,
  output logic [NCH-1:0]    dtr,
  input  logic              int_ack_n,
  output logic              irq
);
  localparam int CH_W = ADDR_W - 1;

  logic              rst_q1, rst_q2;
  logic [DW-1:0]     ch_rdata [NCH];
  logic [NCH-1:0]    ch_irq;
  logic [CH_W-1:0]   ch_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  assign ch_idx = addr[ADDR_W-1:1];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    uart_chan u_ch (
      .clk(clk), .rst_n(rst_q2),
      .sel(cs && (ch_idx == CH_W'(i))), .wr(wr), .rd(rd), .is_data(addr[0]),
      .wdata(wdata), .rdata(ch_rdata[i]), .rxd(rxd[i]), .cts(cts[i]),
      .int_ack_n(int_ack_n), .txd(txd[i]), .rts(rts[i]), .dtr(dtr[i]),
      .irq(ch_irq[i])
    );
  end

  assign rdata = ch_rdata[ch_idx];
  assign irq   = |ch_irq;
endmodule

// File: rtl/uart_dual_chk.sv
module uart_dual_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cs,
  input logic           wr,
  input logic           int_ack_n,
  input logic           irq,
  input logic [NCH-1:0] rts,
  input logic [NCH-1:0] dtr
);
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && int_ack_n) |=> irq);  // R11

  AST_IRQ_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !int_ack_n |=> !irq);  // R11

  AST_RTS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rts) |-> $past(cs && wr));  // R6

  AST_DTR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dtr) |-> $past(cs && wr));  // R6
endmodule

bind uart_dual uart_dual_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .int_ack_n(int_ack_n),
  .irq(irq), .rts(rts), .dtr(dtr)
);

// File: tb/uart_dual_test.sv
module uart_dual_test;
  logic       clk = 1'b0;
  logic       rst_n, cs, wr, rd, int_ack_n;
  logic [1:0] addr, rxd, cts, txd, rts, dtr;
  logic [7:0] wdata, rdata;
  logic       irq;

  int tests = 0, fails = 0;
  int bit_clks [2];
  bit par_en [2], par_even [2], two_stop [2];
  int mon_seen [2];
  logic [7:0] exp_q0 [$], exp_q1 [$];

  always #10 clk = ~clk;

  uart_dual uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rxd(rxd), .cts(cts), .txd(txd),
    .rts(rts), .dtr(dtr), .int_ack_n(int_ack_n), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int ch, input bit dport, input logic [7:0] v);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = {ch[0], dport}; wdata = v;
    @(posedge clk); #1;
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input int ch, input bit dport, output logic [7:0] v);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = {ch[0], dport};
    #2 v = rdata;
    @(posedge clk); #1;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic reg_wr(input int ch, input logic [7:0] idx, input logic [7:0] v);
    bus_wr(ch, 1'b0, idx);
    bus_wr(ch, 1'b0, v);
  endtask

  task automatic reg_rd(input int ch, input logic [7:0] idx, output logic [7:0] v);
    bus_wr(ch, 1'b0, idx);
    bus_rd(ch, 1'b0, v);
  endtask

  // Driver side of the scoreboard: queue the byte, then hand it to the design.
  task automatic tx_send(input int ch, input logic [7:0] v);
    if (ch == 0) exp_q0.push_back(v); else exp_q1.push_back(v);
    bus_wr(ch, 1'b1, v);
  endtask

  task automatic wait_frames(input int ch, input int base, input int n);
    while (mon_seen[ch] < base + n) @(negedge clk);
  endtask

  task automatic rx_drive(input int ch, input logic [7:0] v);
    int bc = bit_clks[ch];
    @(negedge clk); rxd[ch] = 1'b0;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd[ch] = v[i];
      repeat (bc) @(negedge clk);
    end
    if (par_en[ch]) begin
      rxd[ch] = par_even[ch] ? ^v : ~^v;
      repeat (bc) @(negedge clk);
    end
    rxd[ch] = 1'b1;
    repeat (bc * (two_stop[ch] ? 2 : 1) + 4) @(negedge clk);
  endtask

  // Monitor side: decode one frame from txd and compare with the queue.
  task automatic mon_frame(input int ch);
    int bc = bit_clks[ch];
    logic [7:0] b, e;
    repeat (bc / 2) @(negedge clk);
    chk("R9 start bit", int'(txd[ch]), 0);
    for (int i = 0; i < 8; i++) begin
      repeat (bc) @(negedge clk);
      b[i] = txd[ch];
    end
    if (par_en[ch]) begin
      repeat (bc) @(negedge clk);
      chk("R5 parity bit", int'(txd[ch]), int'(par_even[ch] ? ^b : ~^b));
    end
    repeat (bc) @(negedge clk);
    chk("R9 stop bit", int'(txd[ch]), 1);
    if (two_stop[ch]) begin
      repeat (bc) @(negedge clk);
      chk("R5 second stop bit", int'(txd[ch]), 1);
    end
    if (ch == 0 ? exp_q0.size() == 0 : exp_q1.size() == 0) begin
      chk("R9 unexpected frame", int'(b), -1);
    end else begin
      e = (ch == 0) ? exp_q0.pop_front() : exp_q1.pop_front();
      chk("R9 frame data", int'(b), int'(e));
    end
    mon_seen[ch]++;
  endtask

  initial begin
    mon_seen[0] = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (txd[0] === 1'b0) mon_frame(0);
    end
  end

  initial begin
    mon_seen[1] = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (txd[1] === 1'b0) mon_frame(1);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int base, cnt;
    rst_n = 1'b0; cs = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    rxd = 2'b11; cts = 2'b00; int_ack_n = 1'b1;
    bit_clks[0] = 64; bit_clks[1] = 64;
    par_en = '{0, 0}; par_even = '{0, 0}; two_stop = '{0, 0};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 reset state
    chk("R4 txd idle", int'(txd), 3);
    chk("R4 rts", int'(rts), 0);
    chk("R4 dtr", int'(dtr), 0);
    chk("R4 irq", int'(irq), 0);
    bus_rd(0, 1'b0, v); chk("R4 status after reset", int'(v), 'h04);
    reg_rd(0, 8'd5, v); chk("R4 register cleared", int'(v), 0);

    // R2 / R3 pointer and readback
    reg_wr(0, 8'd12, 8'hAB);
    reg_rd(0, 8'd12, v); chk("R2 pointer reaches register 12", int'(v), 'hAB);
    bus_rd(0, 1'b0, v); chk("R2 pointer back to 0", int'(v), 'h04);
    reg_wr(0, 8'd15, 8'h3C);
    reg_rd(0, 8'd15, v); chk("R3 readback register 15", int'(v), 'h3C);
    reg_rd(1, 8'd12, v); chk("R1 other channel untouched", int'(v), 0);

    // Channel 0: x16, 1 stop, no parity, TC = 0
    reg_wr(0, 8'd4, 8'h44);
    reg_wr(0, 8'd3, 8'hC1);
    reg_wr(0, 8'd5, 8'hEA);
    reg_wr(0, 8'd11, 8'h56);
    reg_wr(0, 8'd12, 8'h00);
    reg_wr(0, 8'd13, 8'h00);
    reg_wr(0, 8'd14, 8'h01);
    repeat (2) @(negedge clk);
    chk("R6 rts driven", int'(rts), 1);
    chk("R6 dtr driven", int'(dtr), 1);

    // R8 bit period and R9 scoreboard frames
    base = mon_seen[0];
    tx_send(0, 8'h55);
    while (txd[0] !== 1'b0) @(negedge clk);
    while (txd[0] !== 1'b1) @(negedge clk);
    cnt = 0;
    while (txd[0] === 1'b1) begin cnt++; @(negedge clk); end
    chk("R8 bit period 2*16*(0+2)", cnt, 64);
    wait_frames(0, base, 1);
    base = mon_seen[0];
    tx_send(0, 8'hA3); wait_frames(0, base, 1);
    base = mon_seen[0];
    tx_send(0, 8'h00); wait_frames(0, base, 1);
    base = mon_seen[0];
    tx_send(0, 8'hFF); wait_frames(0, base, 1);

    // R10 receive on channel 0
    rx_drive(0, 8'h3C);
    bus_rd(0, 1'b0, v); chk("R10 available flag set", int'(v[0]), 1);
    bus_rd(0, 1'b1, v); chk("R10 received byte", int'(v), 'h3C);
    bus_rd(0, 1'b0, v); chk("R10 flag cleared by read", int'(v[0]), 0);

    // Channel 1: x32, two stops, even parity, TC = 3
    bit_clks[1] = 2 * 32 * 5; par_en[1] = 1; par_even[1] = 1; two_stop[1] = 1;
    reg_wr(1, 8'd4, 8'h8F);
    reg_wr(1, 8'd3, 8'h01);
    reg_wr(1, 8'd5, 8'h08);
    reg_wr(1, 8'd11, 8'h56);
    reg_wr(1, 8'd12, 8'h03);
    reg_wr(1, 8'd13, 8'h00);
    reg_wr(1, 8'd14, 8'h01);
    chk("R1 channel 1 pins independent", int'(rts), 1);
    base = mon_seen[1];
    tx_send(1, 8'hB7); wait_frames(1, base, 1);
    base = mon_seen[1];
    tx_send(1, 8'h01); wait_frames(1, base, 1);
    rx_drive(1, 8'h6A);
    bus_rd(1, 1'b1, v); chk("R5 parity frame received", int'(v), 'h6A);
    bus_rd(0, 1'b0, v); chk("R1 channel 0 flag unaffected", int'(v[0]), 0);

    // R7 auto-enable with CTS low, R12 dropped write
    reg_wr(0, 8'd3, 8'hE1);
    base = mon_seen[0];
    tx_send(0, 8'h81);
    repeat (3 * 64) @(negedge clk);
    chk("R7 held while CTS low", mon_seen[0] - base, 0);
    chk("R7 line idle while CTS low", int'(txd[0]), 1);
    bus_rd(0, 1'b0, v); chk("R7 holding still full", int'(v[2]), 0);
    bus_wr(0, 1'b1, 8'h99);
    cts[0] = 1'b1;
    wait_frames(0, base, 1);
    repeat (3 * 640) @(negedge clk);
    chk("R12 only one frame sent", mon_seen[0] - base, 1);
    bus_rd(0, 1'b0, v); chk("R3 status with CTS high", int'(v), 'h24);

    // R8 generator stopped
    reg_wr(0, 8'd14, 8'h00);
    base = mon_seen[0];
    bus_wr(0, 1'b1, 8'h42);
    repeat (1000) @(negedge clk);
    chk("R8 no frame with generator off", mon_seen[0] - base, 0);
    chk("R8 line idle with generator off", int'(txd[0]), 1);
    exp_q0.push_back(8'h42);
    reg_wr(0, 8'd14, 8'h01);
    wait_frames(0, base, 1);
    chk("R8 frame after generator on", mon_seen[0] - base, 1);

    // R11 sticky interrupt
    reg_wr(0, 8'd1, 8'h01);
    chk("R11 irq low before event", int'(irq), 0);
    rx_drive(0, 8'h5A);
    chk("R11 irq on receive", int'(irq), 1);
    bus_rd(0, 1'b1, v); chk("R10 byte under interrupt", int'(v), 'h5A);
    repeat (3) @(negedge clk);
    chk("R11 irq held after cause cleared", int'(irq), 1);
    @(negedge clk); int_ack_n = 1'b0;
    @(negedge clk); int_ack_n = 1'b1;
    chk("R11 irq cleared by acknowledge", int'(irq), 0);
    reg_wr(1, 8'd1, 8'h02);
    base = mon_seen[1];
    tx_send(1, 8'hC4);
    repeat (20) @(negedge clk);
    chk("R11 irq on holding emptied", int'(irq), 1);
    wait_frames(1, base, 1);
    @(negedge clk); int_ack_n = 1'b0;
    @(negedge clk); int_ack_n = 1'b1;
    chk("R11 irq cleared again", int'(irq), 0);

    repeat (20) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule